// File: doc/BRIEF.md
# Clocked Byte Serial Port

This block moves one byte at a time over a three-wire synchronous link: a shift clock, a serial data output and a serial data input. A CPU-style register bus reaches two locations, a control word and a byte-wide data register. Software loads the byte to send, writes the control word with the start bit set, and then either polls the busy bit or waits for the interrupt. When the port is done, the data register holds the byte that arrived on the input pin.

The shift clock has two possible sources. One source is an internal divider with three rates. The other is an external clock pin, which is brought into the system clock domain through a two-stage synchronizer. The bit order can be least or most significant first. Clearing the start bit while a transfer is running aborts it.

The block has no data stream at its edge. All control and status pins are plain levels.

Top module: `sio8_top`

Register map. `bus_addr` = 0 selects the control word. `bus_addr` = 1 selects the data register. The control word bits are:

- bit 0 `go`: write 1 to start; reads back as busy.
- bit 1 `msb`: bit order.
- bits 3:2 `csel`: clock select.
- bit 4 `dout_en`: data pin enable.
- bit 5 `ck_en`: clock pin output enable.
- bit 6 `ie`: interrupt enable.
- bit 7 `fin`: completion flag.

## Requirements
- R1: The completion flag sets and busy clears on the same clock edge, the one that carries the 8th rising shift edge. With an internal clock this is 16*H system cycles after the start write, where H is half the divide ratio.
- R2: `irq` is high exactly when the completion flag and `ie` are both 1.
- R3: A control write with bit 7 = 0 clears the completion flag. A write with bit 7 = 1 leaves the flag unchanged. Completion in the same cycle wins over a clearing write.
- R4: `csel` selects the shift clock: 00 divides the system clock by 2, 01 by 8, 10 by 32, and 11 selects `sck_in`. The internal clock has a 50% duty cycle, runs only while busy, and idles high.
- R5: `sck_oe` is 1 only when `ck_en` = 1 and an internal clock is selected. `sck_out` carries the internal shift clock.
- R6: With `msb` = 0, bit 0 of the data register is sent first and the first received bit ends in bit 0. With `msb` = 1, bit 7 is sent first and the first received bit ends in bit 7.
- R7: `sdo` changes only on a falling shift edge. `sdi` is sampled on a rising shift edge.
- R8: Writing `go` = 1 clears the bit counter and sets busy. With `csel` = 11 the port waits, with the clock idle, until edges arrive on `sck_in`.
- R9: A control write with `go` = 0 during a transfer stops it. No completion follows, and the internal clock stays high until the next start, which transfers a full 8 bits.
- R10: With `dout_en` = 0, `sdo` follows `gp_dout`.
- R11: The data register reads back the received byte after completion. Writes to it while busy are dropped.
- R12: After reset the control word reads 0, `sck_out` is 1 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = control word, 1 = data register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| sck_in | input | 1 | External shift clock |
| sck_out | output | 1 | Internal shift clock |
| sck_oe | output | 1 | Drive enable for the clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, or `gp_dout` |
| gp_dout | input | 1 | General-purpose value for the data pin |
| irq | output | 1 | Interrupt request |

## Verification
Random bytes are sent and received at the same time, with independent patterns on each side. The random picks cover each internal rate and both bit orders, so a swapped order, a lost bit or a wrong divide ratio shows up in the sent bits, the received byte or the cycle count.

Directed cases add the following:
- An external-clock transfer separates arming from shifting.
- An abort followed by a full restart exposes a bit counter that was not cleared.
- Writes with flag bit 1 and flag bit 0 separate the clear-only behaviour of the completion flag.
- A data write in the middle of a transfer shows whether a write while busy corrupts the bits still to be sent.

// File: rtl/sio8_pkg.sv
`timescale 1ns/1ps
package sio8_pkg;
  typedef enum logic [1:0] {
    CS_FAST = 2'b00,
    CS_MID  = 2'b01,
    CS_SLOW = 2'b10,
    CS_EXT  = 2'b11
  } clksel_e;

  localparam int B_GO   = 0;
  localparam int B_MSB  = 1;
  localparam int B_CSL  = 2;
  localparam int B_DOE  = 4;
  localparam int B_CKE  = 5;
  localparam int B_IE   = 6;
  localparam int B_FIN  = 7;
endpackage

// File: rtl/sio8_clkgen.sv
`timescale 1ns/1ps
module sio8_clkgen import sio8_pkg::*; #(
  parameter int DIV_F = 2,
  parameter int DIV_M = 8,
  parameter int DIV_S = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run,
  input  clksel_e sel,
  input  logic    sck_in,
  output logic    fall_evt,
  output logic    rise_evt,
  output logic    sck_int
);
  localparam int MAXH = DIV_S / 2;
  localparam int CW   = $clog2(MAXH) + 1;

  logic [CW-1:0] hcnt, half_m1;
  logic          sck_q, tick, ext_mode;
  logic [SYNC_STAGES-1:0] sync_q;
  logic          ext_now, ext_prev;

  assign ext_mode = (sel == CS_EXT);

  always_comb begin
    case (sel)
      CS_FAST: half_m1 = CW'(DIV_F / 2 - 1);
      CS_MID:  half_m1 = CW'(DIV_M / 2 - 1);
      CS_SLOW: half_m1 = CW'(DIV_S / 2 - 1);
      default: half_m1 = '0;
    endcase
  end

  assign tick = run && !ext_mode && (hcnt == half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      sck_q <= 1'b1;
    end else if (!run || ext_mode) begin
      hcnt  <= '0;
      sck_q <= 1'b1;
    end else if (tick) begin
      hcnt  <= '0;
      sck_q <= ~sck_q;
    end else begin
      hcnt  <= hcnt + 1'b1;
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[s] <= 1'b1;
        else if (s == 0) sync_q[s] <= sck_in;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign ext_now = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev <= 1'b1;
    else        ext_prev <= ext_now;
  end

  assign fall_evt = ext_mode ? (run && ext_prev && !ext_now) : (tick && sck_q);
  assign rise_evt = ext_mode ? (run && !ext_prev && ext_now) : (tick && !sck_q);
  assign sck_int  = sck_q;

  p_one_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_evt && rise_evt));
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> sck_int);
endmodule

// File: rtl/sio8_shifter.sv
`timescale 1ns/1ps
module sio8_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_data,
  input  logic            restart,
  input  logic            fall_evt,
  input  logic            rise_evt,
  input  logic            msb_first,
  input  logic            sdi,
  output logic [BITS-1:0] sreg,
  output logic            sdo_bit,
  output logic            last
);
  localparam int CNTW = $clog2(BITS + 1);

  logic [CNTW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg <= '0;
    else if (load) sreg <= load_data;
    else if (rise_evt)
      sreg <= msb_first ? {sreg[BITS-2:0], sdi} : {sdi, sreg[BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (restart) cnt <= '0;
    else if (rise_evt) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sdo_bit <= 1'b1;
    else if (fall_evt) sdo_bit <= msb_first ? sreg[BITS-1] : sreg[0];
  end

  assign last = rise_evt && (cnt == CNTW'(BITS - 1));

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNTW'(BITS));
  p_sdo_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(sdo_bit));
endmodule

// File: rtl/sio8_top.sv
`timescale 1ns/1ps
module sio8_top import sio8_pkg::*; #(
  parameter int BITS  = 8,
  parameter int DIV_F = 2,
  parameter int DIV_M = 8,
  parameter int DIV_S = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       sck_in,
  output logic       sck_out,
  output logic       sck_oe,
  input  logic       sdi,
  output logic       sdo,
  input  logic       gp_dout,
  output logic       irq
);
  logic    busy_q, fin_q, ie_q, cke_q, doe_q, msb_q;
  clksel_e sel_q;
  logic    ctrl_wr, data_wr, restart, load;
  logic    fall_evt, rise_evt, sck_int, last, sdo_bit;
  logic [BITS-1:0] sreg;

  assign ctrl_wr = bus_wr && !bus_addr;
  assign data_wr = bus_wr &&  bus_addr;
  assign restart = ctrl_wr && bus_wdata[B_GO];
  assign load    = data_wr && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      cke_q <= 1'b0;
      doe_q <= 1'b0;
      msb_q <= 1'b0;
      sel_q <= CS_FAST;
    end else if (ctrl_wr) begin
      ie_q  <= bus_wdata[B_IE];
      cke_q <= bus_wdata[B_CKE];
      doe_q <= bus_wdata[B_DOE];
      msb_q <= bus_wdata[B_MSB];
      sel_q <= clksel_e'(bus_wdata[B_CSL +: 2]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else if (ctrl_wr) busy_q <= bus_wdata[B_GO];
    else if (last) busy_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fin_q <= 1'b0;
    else if (last) fin_q <= 1'b1;
    else if (ctrl_wr && !bus_wdata[B_FIN]) fin_q <= 1'b0;
  end

  sio8_clkgen #(
    .DIV_F(DIV_F), .DIV_M(DIV_M), .DIV_S(DIV_S), .SYNC_STAGES(2)
  ) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy_q), .sel(sel_q), .sck_in(sck_in),
    .fall_evt(fall_evt), .rise_evt(rise_evt), .sck_int(sck_int)
  );

  sio8_shifter #(.BITS(BITS)) u_shf (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(bus_wdata[BITS-1:0]),
    .restart(restart), .fall_evt(fall_evt), .rise_evt(rise_evt),
    .msb_first(msb_q), .sdi(sdi), .sreg(sreg), .sdo_bit(sdo_bit), .last(last)
  );

  assign bus_rdata = bus_addr ? 8'(sreg)
                              : {fin_q, ie_q, cke_q, doe_q, sel_q, msb_q, busy_q};
  assign sck_out = sck_int;
  assign sck_oe  = cke_q && (sel_q != CS_EXT);
  assign sdo     = doe_q ? sdo_bit : gp_dout;
  assign irq     = fin_q && ie_q;

  p_fin_ends_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin_q) |-> (!busy_q && $past(busy_q)));
  p_fin_w1_noset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[B_FIN] && !fin_q && !last) |=> !fin_q);
  p_abort_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !bus_wdata[B_GO]) |=> (!busy_q && !fin_q) || $past(bus_wdata[B_FIN]));
  p_busy_write_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy_q && !rise_evt) |=> $stable(sreg));
endmodule

// File: tb/sim_sio8_top.sv
`timescale 1ns/1ps
module sim_sio8_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       sck_in = 1'b1, sck_out, sck_oe;
  logic       sdi = 1'b0, sdo, gp_dout = 1'b1, irq;

  int nvec = 0, nfail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sio8_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_in(sck_in),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo),
    .gp_dout(gp_dout), .irq(irq)
  );

  function automatic int bpos(int i, bit msb);
    return msb ? 7 - i : i;
  endfunction

  function automatic int half_of(logic [1:0] sel);
    return (sel == 2'b00) ? 1 : (sel == 2'b01) ? 4 : 16;
  endfunction

  function automatic logic [7:0] ctrl_word(bit fin, bit ie, bit cke, bit doe,
                                           logic [1:0] sel, bit msb, bit go);
    return {fin, ie, cke, doe, sel, msb, go};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b0;
    #1;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata; bus_addr = 1'b0;
  endtask

  task automatic run_int(logic [7:0] tx, logic [7:0] rx, logic [1:0] sel,
                         bit msb, bit ie, bit mid_wr);
    logic [7:0] got_tx = '0, r;
    int n = 0, fb = 0;
    bit prev = 1'b1, busy = 1'b1;
    wr(1'b1, tx);
    wr(1'b0, ctrl_word(1'b0, ie, 1'b1, 1'b1, sel, msb, 1'b1));
    chk("R5 sck_oe internal", sck_oe, 1);
    while (busy && n < 2000) begin
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 1'b0;
      #1;
      n++;
      busy = bus_rdata[0];
      if (prev && !sck_out && fb < 8) begin
        got_tx[bpos(fb, msb)] = sdo;
        sdi = rx[bpos(fb, msb)];
        fb++;
      end
      prev = sck_out;
      if (mid_wr && n == 5) begin
        bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = ~tx;
      end
    end
    bus_wr = 1'b0;
    chk("R1/R4 transfer cycles", n, 16 * half_of(sel));
    chk("R6/R7 sent bits", got_tx, tx);
    rd(1'b1, r);
    chk("R11/R6 received byte", r, rx);
    rd(1'b0, r);
    chk("R1 flag set busy clear", {r[7], r[0]}, 2'b10);
    chk("R2 irq after done", irq, ie);
    chk("R4 clock idles high", sck_out, 1);
  endtask

  initial begin
    logic [7:0] r;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    #1;
    chk("R12 ctrl reset", bus_rdata, 0);
    chk("R12 sck_out reset", sck_out, 1);
    chk("R12 irq reset", irq, 0);
    chk("R10 sdo follows gp", sdo, 1);
    rst_n = 1'b1;
    @(negedge clk);

    gp_dout = 1'b0; #1;
    chk("R10 sdo follows gp low", sdo, 0);
    gp_dout = 1'b1;

    run_int(8'hA5, 8'h3C, 2'b00, 1'b0, 1'b1, 1'b0);
    run_int(8'h81, 8'hC3, 2'b01, 1'b1, 1'b0, 1'b0);
    run_int(8'h1E, 8'h96, 2'b10, 1'b0, 1'b1, 1'b0);

    // R3: writing 1 to the flag keeps it; writing 0 clears it
    wr(1'b0, ctrl_word(1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0));
    rd(1'b0, r);
    chk("R3 write one keeps flag", r[7], 1);
    chk("R2 irq held", irq, 1);
    wr(1'b0, ctrl_word(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0));
    rd(1'b0, r);
    chk("R3 write zero clears flag", r[7], 0);
    chk("R2 irq drops", irq, 0);

    // R11: a data write in the middle of a transfer must not alter the sent bits
    run_int(8'h5A, 8'hF0, 2'b01, 1'b0, 1'b0, 1'b1);

    // R10: data pin released when the output enable is 0
    wr(1'b0, ctrl_word(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0));
    gp_dout = 1'b0; #1;
    chk("R10 released low", sdo, 0);
    gp_dout = 1'b1; #1;
    chk("R10 released high", sdo, 1);
    chk("R5 sck_oe off", sck_oe, 0);

    // R9: abort mid transfer, then a full restart
    wr(1'b1, 8'h77);
    wr(1'b0, ctrl_word(1'b0, 1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 1'b1));
    repeat (40) @(negedge clk);
    wr(1'b0, ctrl_word(1'b0, 1'b1, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0));
    rd(1'b0, r);
    chk("R9 abort clears busy", {r[7], r[0]}, 2'b00);
    begin
      int bad = 0;
      for (int k = 0; k < 600; k++) begin
        @(negedge clk); #1;
        if (!sck_out || irq) bad++;
      end
      chk("R9 idle after abort", bad, 0);
    end
    rd(1'b0, r);
    chk("R9 no completion after abort", r[7], 0);
    run_int(8'hC6, 8'h2B, 2'b10, 1'b1, 1'b1, 1'b0);

    // R8: external clock arms and waits, R5 pin stays input
    begin
      logic [7:0] tx = 8'hB4, rx = 8'h69, got_tx = '0;
      wr(1'b1, tx);
      wr(1'b0, ctrl_word(1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1));
      chk("R5 sck_oe external", sck_oe, 0);
      repeat (20) @(negedge clk);
      #1;
      rd(1'b0, r);
      chk("R8 armed waits", {r[7], r[0]}, 2'b01);
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        sck_in = 1'b0; sdi = rx[i];
        repeat (6) @(negedge clk);
        got_tx[i] = sdo;
        sck_in = 1'b1;
        repeat (6) @(negedge clk);
      end
      #1;
      chk("R8 external sent bits", got_tx, tx);
      rd(1'b1, r);
      chk("R8 external received", r, rx);
      rd(1'b0, r);
      chk("R8 external done", {r[7], r[0]}, 2'b10);
    end

    // random traffic over the internal rates and both orders
    for (int t = 0; t < 24; t++) begin
      logic [1:0] s = 2'($urandom_range(0, 2));
      run_int(8'($urandom), 8'($urandom), s, 1'($urandom), 1'($urandom), 1'b0);
    end

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nvec++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule